// File: doc/BRIEF.md
# DDC EDID Block Reader

This block fetches display identification data one byte at a time through a separate I2C master that handles the bus itself. After a start strobe it reads a 128-byte block chosen by a block number. It turns the block number into a segment pointer and a byte offset inside that segment. It issues one read command per byte and writes each returned byte into a 256-byte buffer. Block 0 is read with a plain one-byte read. Any other block uses the extended read, which sends the segment pointer first.

Each byte has a timeout. If no completion event arrives in time, the block pulses a reset to the I2C master and starts the whole block again from byte 0. A block gets a bounded number of attempts. When the first block has been read, its extension-count byte (offset 126) decides whether the following block is fetched into the upper half of the buffer. The reported length is 128 or 256, and it is 0 when the first block fails. The master's standard-mode SCL timing and the bit-level protocol are not part of this block.

Top module: `edid_ddc_reader`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `cmd_valid`, `buf_we` and `i2c_rst` are 0 and `edid_len` is 0.
- R2: Each read command for byte index i (0..127) of block b carries `cmd_seg` = b>>1 and `cmd_addr` = {b[0], i[6:0]}. `cmd_ext` is 1 (segment-pointer read) exactly when b is not 0. `cmd_valid` is a one-cycle pulse.
- R3: A byte counts as done only on a cycle where `i2c_done` is high while a command is waiting. That cycle writes `i2c_rdata` into the buffer at address {second_block, i}, and the next byte's command follows.
- R4: `i2c_err` never counts as byte completion. The read keeps waiting for `i2c_done` or the timeout.
- R5: After a command, a completion that arrives within TIMEOUT_CYC waiting cycles is accepted, including on the last of those cycles. Without one, `i2c_rst` pulses for one cycle and the block restarts at byte index 0.
- R6: A block gets at most MAX_TRIES attempts (default 5). If the first block uses them all up, the read ends with `err`=1 and `edid_len`=0.
- R7: If byte 126 of the first block is nonzero, block number+1 is read into buffer addresses 128..255 and `edid_len`=256. Otherwise the read ends after the first block with `edid_len`=128.
- R8: If the second block uses up its attempts, the read ends with `err`=1 and `edid_len`=128.
- R9: `done` is a one-cycle pulse, after which `busy` is 0. A start strobe while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read when idle |
| block_num | input | 8 | First block to read |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| err | output | 1 | Last read failed |
| edid_len | output | 9 | Valid bytes in buffer (0, 128, 256) |
| cmd_valid | output | 1 | Read command pulse to the I2C master |
| cmd_ext | output | 1 | 1 = send segment pointer before the byte read |
| cmd_seg | output | 8 | Segment pointer |
| cmd_addr | output | 8 | Byte offset within the segment |
| i2c_done | input | 1 | Byte read complete, data valid |
| i2c_err | input | 1 | Bus error event from the master |
| i2c_rdata | input | 8 | Byte returned by the master |
| i2c_rst | output | 1 | One-cycle soft reset to the master |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 8 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The bench models the display side as a memory of four blocks. Each command is decoded back into a block and an offset, so a wrong segment or half-select returns bytes from the wrong block and shows up in the buffer compare. It drops chosen bytes a set number of times and sends error events on them. A design that accepted an error as completion would store garbage, and one that miscounted attempts would report the wrong reset count, error flag or length. It also targets these cases: an extension byte of zero versus nonzero, including a failure on byte 126 itself; odd starting blocks that cross a segment; a completion on the very last allowed cycle, which a timer off by one would reject; and a start strobe during a read, which must not disturb it.

// File: rtl/edid_rd_pkg.sv
package edid_rd_pkg;
  localparam int BLK_BYTES = 128;
  localparam int IDX_W     = $clog2(BLK_BYTES);
  localparam int BLK_W     = 8;
  localparam int LEN_W     = IDX_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FINISH} rd_state_t;

  function automatic logic [BLK_W-1:0] seg_of(input logic [BLK_W-1:0] blk);
    return {1'b0, blk[BLK_W-1:1]};
  endfunction

  function automatic logic [IDX_W:0] off_of(input logic [BLK_W-1:0] blk,
                                            input logic [IDX_W-1:0] idx);
    return {blk[0], idx};
  endfunction

  function automatic logic uses_segment(input logic [BLK_W-1:0] blk);
    return blk != '0;
  endfunction

  function automatic logic [LEN_W-1:0] good_len(input logic second);
    return second ? LEN_W'(2*BLK_BYTES) : LEN_W'(BLK_BYTES);
  endfunction

  function automatic logic [LEN_W-1:0] fail_len(input logic second);
    return second ? LEN_W'(BLK_BYTES) : '0;
  endfunction
endpackage

// File: rtl/edid_byte_timer.sv
module edid_byte_timer #(
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(TIMEOUT_CYC - 1));

  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/edid_try_counter.sv
module edid_try_counter #(
  parameter int MAX_TRIES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TW'(MAX_TRIES - 1));

  assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < TW'(MAX_TRIES));
endmodule

// File: rtl/edid_ddc_reader.sv
module edid_ddc_reader
  import edid_rd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000000,
  parameter int MAX_TRIES   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] block_num,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [8:0] edid_len,
  output logic       cmd_valid,
  output logic       cmd_ext,
  output logic [7:0] cmd_seg,
  output logic [7:0] cmd_addr,
  input  logic       i2c_done,
  input  logic       i2c_err,
  input  logic [7:0] i2c_rdata,
  output logic       i2c_rst,
  output logic       buf_we,
  output logic [7:0] buf_addr,
  output logic [7:0] buf_wdata
);
  rd_state_t        state;
  logic [BLK_W-1:0] base_blk;
  logic             second;
  logic [IDX_W-1:0] idx;
  logic             ext_nz;
  logic [LEN_W-1:0] len_q;
  logic             err_q;

  logic [BLK_W-1:0] cur_blk;
  logic             waiting, byte_ok, expired, tmo, last_byte, try_last;
  logic             go_ext, try_clear, try_bump;

  assign cur_blk   = base_blk + BLK_W'(second);
  assign waiting   = (state == ST_WAIT);
  assign byte_ok   = waiting && i2c_done;
  assign tmo       = expired && !i2c_done;
  assign last_byte = (idx == IDX_W'(BLK_BYTES - 1));
  assign go_ext    = byte_ok && last_byte && !second && ext_nz;
  assign try_clear = ((state == ST_IDLE) && start) || go_ext;
  assign try_bump  = tmo && !try_last;

  edid_byte_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(waiting), .expired(expired));

  edid_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clear(try_clear), .bump(try_bump), .last(try_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base_blk <= '0;
      second   <= 1'b0;
      idx      <= '0;
      ext_nz   <= 1'b0;
      len_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          base_blk <= block_num;
          second   <= 1'b0;
          idx      <= '0;
          ext_nz   <= 1'b0;
          len_q    <= '0;
          err_q    <= 1'b0;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (byte_ok) begin
            if (!second && idx == IDX_W'(BLK_BYTES - 2))
              ext_nz <= (i2c_rdata != 8'd0);
            if (go_ext) begin
              second <= 1'b1;
              idx    <= '0;
              state  <= ST_ISSUE;
            end else if (last_byte) begin
              len_q <= good_len(second);
              state <= ST_FINISH;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_ISSUE;
            end
          end else if (tmo) begin
            if (try_last) begin
              err_q <= 1'b1;
              len_q <= fail_len(second);
              state <= ST_FINISH;
            end else begin
              idx   <= '0;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FINISH);
  assign err       = err_q;
  assign edid_len  = len_q;
  assign cmd_valid = (state == ST_ISSUE);
  assign cmd_ext   = uses_segment(cur_blk);
  assign cmd_seg   = seg_of(cur_blk);
  assign cmd_addr  = off_of(cur_blk, idx);
  assign i2c_rst   = tmo;
  assign buf_we    = byte_ok;
  assign buf_addr  = {second, idx};
  assign buf_wdata = i2c_rdata;

  assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_write_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (cmd_valid || done));

  assert_err_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && i2c_err && !i2c_done && !tmo) |=> (waiting && $stable(idx)));

  assert_rst_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_rst |=> (!i2c_rst && (done || (cmd_valid && cmd_addr[6:0] == 7'd0))));

  assert_len_values_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((edid_len == 9'd0 && err) || edid_len == 9'd128 ||
              (edid_len == 9'd256 && !err)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/edid_ddc_reader_test.sv
module edid_ddc_reader_test;
  localparam int TMO = 40;

  logic       clk = 0, rst_n = 0, start = 0;
  logic [7:0] block_num = 0;
  logic       busy, done, err, cmd_valid, cmd_ext, i2c_rst, buf_we;
  logic [8:0] edid_len;
  logic [7:0] cmd_seg, cmd_addr, buf_addr, buf_wdata;
  logic       i2c_done = 0, i2c_err = 0;
  logic [7:0] i2c_rdata = 0;

  edid_ddc_reader #(.TIMEOUT_CYC(TMO), .MAX_TRIES(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .block_num(block_num),
    .busy(busy), .done(done), .err(err), .edid_len(edid_len),
    .cmd_valid(cmd_valid), .cmd_ext(cmd_ext), .cmd_seg(cmd_seg), .cmd_addr(cmd_addr),
    .i2c_done(i2c_done), .i2c_err(i2c_err), .i2c_rdata(i2c_rdata), .i2c_rst(i2c_rst),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata));

  always #4 clk = ~clk;

  logic [7:0] mem [0:511];
  logic [7:0] cap [0:255];
  int checks = 0, fails = 0;
  int fail_blk = -1, fail_idx = 0, fail_left = 0, lat_fixed = 0;
  int rst_cnt = 0, ext_bad = 0;
  bit running = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int min5(input int v);
    return (v > 5) ? 5 : v;
  endfunction

  // display-side responder: decodes segment/offset back into block and byte
  initial begin
    @(posedge rst_n);
    @(posedge clk); #2;
    forever begin
      if (!cmd_valid) begin
        @(posedge clk); #2;
      end else begin
        int b, i, lat;
        b = {24'd0, cmd_seg[6:0], cmd_addr[7]};
        i = int'(cmd_addr[6:0]);
        if (cmd_ext != (b != 0)) ext_bad++;
        if (b == fail_blk && i == fail_idx && fail_left > 0) begin
          fail_left--;
          @(posedge clk); #2 i2c_err = 1;     // R4: error event, not completion
          @(posedge clk); #2 i2c_err = 0;
        end else begin
          lat = (lat_fixed > 0) ? lat_fixed : 1 + int'($urandom % 5);
          repeat (lat) @(posedge clk);
          #2;
          i2c_done  = 1;
          i2c_rdata = (b < 4) ? mem[b*128 + i] : 8'h00;
          @(posedge clk); #2;
          i2c_done = 0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (running && buf_we) cap[buf_addr] = buf_wdata;
      if (running && i2c_rst) rst_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic run_case(input int bb, input int extv, input int fb, input int fi,
                          input int fc, input int lat, input bit poke);
    int e_err, e_len, e_rst, bad;
    for (int j = 0; j < 512; j++) mem[j] = 8'($urandom);
    for (int j = 0; j < 256; j++) cap[j] = 8'h5A;
    mem[bb*128 + 126] = 8'(extv);
    fail_blk = fb; fail_idx = fi; fail_left = fc; lat_fixed = lat;
    rst_cnt = 0; ext_bad = 0; running = 1;
    @(posedge clk); #2;
    block_num = 8'(bb); start = 1;
    @(posedge clk); #2;
    start = 0;
    if (poke) begin
      repeat (30) @(posedge clk);
      #2 block_num = 8'd3; start = 1;   // R9: must be ignored while busy
      @(posedge clk); #2 start = 0;
    end
    while (!done) begin
      @(posedge clk); #2;
    end
    // expected outcome from the requirements
    if (fb == bb && fc >= 5) begin
      e_err = 1; e_len = 0; e_rst = 5;
    end else begin
      e_rst = (fb == bb) ? fc : 0;
      if (extv != 0) begin
        if (fb == bb + 1) e_rst += min5(fc);
        e_err = (fb == bb + 1 && fc >= 5) ? 1 : 0;
        e_len = e_err ? 128 : 256;
      end else begin
        e_err = 0; e_len = 128;
      end
    end
    chk("R6/R8 err flag", int'(err), e_err);
    chk("R7 edid_len", int'(edid_len), e_len);
    chk("R5 master resets", rst_cnt, e_rst);
    bad = 0;
    for (int j = 0; j < e_len; j++) if (cap[j] != mem[bb*128 + j]) bad++;
    chk("R2/R3/R4 buffer content mismatches", bad, 0);
    chk("R2 cmd_ext encoding errors", ext_bad, 0);
    @(posedge clk); #2;
    chk("R9 done pulse then idle", int'({done, busy}), 0);
    running = 0;
    fail_left = 0; fail_blk = -1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #3;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err/len", int'({err, edid_len}), 0);
    chk("R1 cmd/we/rst", int'({cmd_valid, buf_we, i2c_rst}), 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // directed corner cases
    run_case(0, 0, -1, 0, 0, 0, 0);      // R7 no extension
    run_case(0, 5, -1, 0, 0, 0, 1);      // R7 extension, R9 start while busy
    run_case(2, 1, 2, 3, 2, 0, 0);       // R5 retries then success
    run_case(0, 0, 0, 127, 5, 0, 0);     // R6 first block exhausted
    run_case(0, 1, 1, 0, 5, 0, 0);       // R8 second block exhausted
    run_case(1, 9, 1, 126, 4, 0, 0);     // R2 odd block crosses segment
    run_case(0, 0, -1, 0, 0, TMO, 0);    // R5 done on last allowed cycle
    run_case(1, 0, 1, 5, 1, 0, 0);       // R2 odd block, no extension
    // constrained random cases
    for (int k = 0; k < 8; k++) begin
      int bb, ev;
      bb = int'($urandom % 3);
      ev = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 255);
      run_case(bb, ev, bb + int'($urandom % 2), int'($urandom % 128),
               int'($urandom % 7), 0, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule